// File: doc/BRIEF.md
# Interrupt Message Aggregator

This block gathers eleven level-type interrupt lines, samples them once per clock and keeps three views of them: the live level of each line, a sticky record of lines that went high, and two request views that split the enabled, active lines by a per-line steering bit. Software reaches all of this through a plain 32-bit register port with a read strobe and a write strobe. Read data is combinational from the offset presented in the same cycle.

When a line goes from low to high and its enable bit is set, the block posts one memory write message towards a processor. The steering bit of that line picks one of two address registers. The message address is that register with its five low bits forced to zero. The message data is those five low bits. Messages leave on a valid/ready pair and are held stable until they are accepted. Triggers that come in while the output is busy are counted per address register and sent later.

Top module: `irq_msg_agg`

## Requirements
- R1: After reset, msg_valid is 0, and the level, pending, enable and steering registers read 0. Both address registers read the parameter ADDR_RST (default 0xF000_0003).
- R2: The level register (offset 0x028) shows each line as sampled at the most recent clock edge. A pulse that rises and falls between two edges is not seen. Bit 9 is unused: it always reads 0 in the level and pending registers, because it is excluded by SRC_USED (default 0x5FF).
- R3: A pending bit (offset 0x01C) is set at an edge where its line is sampled high while its level bit was clear. The bit stays set after the line falls, until a clearing access.
- R4: A read strobe at the pending offset returns the current value and clears the register at that edge. A write strobe there clears it whatever the data. A rising line sampled at the same edge still sets its pending bit.
- R5: Request view 0 (offset 0x00C) reads level AND enable AND NOT steering. Request view 1 (offset 0x014) reads level AND enable AND steering.
- R6: Writes to offsets 0x00C, 0x014 and 0x028 change nothing that can be read back.
- R7: A rising line whose enable bit (offset 0x018) is set produces exactly one message. If its steering bit (offset 0x024) is 1, the message uses address register 1 (offset 0x010); otherwise it uses address register 0 (offset 0x004). msg_valid rises after the second clock edge that follows the line being first driven high. A rising line whose enable bit is clear sends no message but still sets its pending bit.
- R8: A message carries address = register with bits [4:0] cleared, and data = register bits [4:0] zero-extended to 32 bits.
- R9: While msg_valid is 1 and msg_ready is 0, msg_valid, msg_addr and msg_data hold their values.
- R10: Triggers that arrive while the output is waiting are counted per address register, up to 2^CNT_W-1 each, and are all sent later. Several enabled lines rising at the same edge give one message each.
- R11: When both address registers have messages owed, the output alternates between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 11 | Level interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears pending at its offset) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| msg_valid | output | 1 | Message write request |
| msg_ready | input | 1 | Message accepted when high with msg_valid |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The assertions check on every cycle that the level register follows the sampled lines and never shows the unused bit. They also check that pending bits only leave by a clearing access, that a clearing access leaves only fresh rises, and that a stalled message holds still with its address aligned. The choice of address register by steering, the enable gating, exactly how many messages come out of stacked and simultaneous triggers, the alternation between address registers, and the ignoring of read-only writes can only be shown by the bench's scenarios, which count and compare the delivered messages.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

    localparam int RW = 32;
    localparam int OW = 12;

    localparam logic [OW-1:0] OFS_ADDR0 = 12'h004;
    localparam logic [OW-1:0] OFS_VIEW0 = 12'h00C;
    localparam logic [OW-1:0] OFS_ADDR1 = 12'h010;
    localparam logic [OW-1:0] OFS_VIEW1 = 12'h014;
    localparam logic [OW-1:0] OFS_ENA   = 12'h018;
    localparam logic [OW-1:0] OFS_PEND  = 12'h01C;
    localparam logic [OW-1:0] OFS_STEER = 12'h024;
    localparam logic [OW-1:0] OFS_LEVEL = 12'h028;

    localparam int LOW_BITS = 5;

    typedef struct packed {
        logic [RW-1:0] addr;
        logic [RW-1:0] data;
    } msg_t;

    typedef enum logic {
        CH_ZERO = 1'b0,
        CH_ONE  = 1'b1
    } chan_e;

    function automatic msg_t msg_from_reg(input logic [RW-1:0] r);
        msg_t m;
        m.addr = {r[RW-1:LOW_BITS], {LOW_BITS{1'b0}}};
        m.data = {{(RW-LOW_BITS){1'b0}}, r[LOW_BITS-1:0]};
        return m;
    endfunction

endpackage

// File: rtl/irq_lvl_track.sv
module irq_lvl_track #(
    parameter int              NSRC     = 11,
    parameter logic [NSRC-1:0] SRC_USED = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] irq_in,
    input  logic            clr_pend,
    output logic [NSRC-1:0] level,
    output logic [NSRC-1:0] pending,
    output logic [NSRC-1:0] rise
);

    logic [NSRC-1:0] live;

    always_comb begin
        live = irq_in & SRC_USED;
        rise = live & ~level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level   <= '0;
            pending <= '0;
        end else begin
            level   <= live;
            pending <= (clr_pend ? '0 : pending) | rise;
        end
    end

endmodule

// File: rtl/irq_msg_regs.sv
module irq_msg_regs
    import irq_msg_pkg::*;
#(
    parameter int          NSRC     = 11,
    parameter logic [RW-1:0] ADDR_RST = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [OW-1:0]   reg_addr,
    input  logic [RW-1:0]   reg_wdata,
    input  logic [NSRC-1:0] level,
    input  logic [NSRC-1:0] pending,
    output logic [RW-1:0]   areg0,
    output logic [RW-1:0]   areg1,
    output logic [NSRC-1:0] ena,
    output logic [NSRC-1:0] steer,
    output logic            clr_pend,
    output logic [RW-1:0]   reg_rdata
);

    localparam int PADW = RW - NSRC;

    logic [NSRC-1:0] view0;
    logic [NSRC-1:0] view1;

    assign view0    = level & ena & ~steer;
    assign view1    = level & ena & steer;
    assign clr_pend = (reg_rd || reg_wr) && (reg_addr == OFS_PEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            areg0 <= ADDR_RST;
            areg1 <= ADDR_RST;
            ena   <= '0;
            steer <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_ADDR0: areg0 <= reg_wdata;
                OFS_ADDR1: areg1 <= reg_wdata;
                OFS_ENA:   ena   <= reg_wdata[NSRC-1:0];
                OFS_STEER: steer <= reg_wdata[NSRC-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_ADDR0: reg_rdata = areg0;
            OFS_ADDR1: reg_rdata = areg1;
            OFS_VIEW0: reg_rdata = {{PADW{1'b0}}, view0};
            OFS_VIEW1: reg_rdata = {{PADW{1'b0}}, view1};
            OFS_ENA:   reg_rdata = {{PADW{1'b0}}, ena};
            OFS_PEND:  reg_rdata = {{PADW{1'b0}}, pending};
            OFS_STEER: reg_rdata = {{PADW{1'b0}}, steer};
            OFS_LEVEL: reg_rdata = {{PADW{1'b0}}, level};
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_msg_credit.sv
module irq_msg_credit #(
    parameter int NSRC  = 11,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  hits,
    input  logic             take,
    output logic [CNT_W-1:0] cnt
);

    localparam int CMAX = (1 << CNT_W) - 1;

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        int nxt;
        nxt = int'(cnt) + $countones(hits) - (take ? 1 : 0);
        if (nxt > CMAX) nxt = CMAX;
        cnt_d = CNT_W'(nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_d;
    end

endmodule

// File: rtl/irq_msg_queue.sv
module irq_msg_queue
    import irq_msg_pkg::*;
#(
    parameter int NSRC  = 11,
    parameter int CNT_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] rise,
    input  logic [NSRC-1:0] ena,
    input  logic [NSRC-1:0] steer,
    input  logic [RW-1:0]   areg0,
    input  logic [RW-1:0]   areg1,
    input  logic            msg_ready,
    output logic            msg_valid,
    output logic [RW-1:0]   msg_addr,
    output logic [RW-1:0]   msg_data
);

    localparam int NCH = 2;

    logic [NCH-1:0]        take;
    logic [NCH-1:0]        owed;
    logic [NCH-1:0][CNT_W-1:0] cnt;
    chan_e                 last_ch;
    chan_e                 pick;
    logic                  load;
    msg_t                  out_q;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [NSRC-1:0] hits;
        assign hits    = rise & ena & ((g == 1) ? steer : ~steer);
        assign owed[g] = (cnt[g] != '0);
        irq_msg_credit #(.NSRC(NSRC), .CNT_W(CNT_W)) credit_i (
            .clk  (clk),
            .rst  (rst),
            .hits (hits),
            .take (take[g]),
            .cnt  (cnt[g])
        );
    end

    always_comb begin
        load = (!msg_valid || msg_ready) && (owed != '0);
        if (owed[1] && (!owed[0] || last_ch == CH_ZERO)) pick = CH_ONE;
        else                                             pick = CH_ZERO;
        take[0] = load && (pick == CH_ZERO);
        take[1] = load && (pick == CH_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            out_q     <= '0;
            last_ch   <= CH_ONE;
        end else if (load) begin
            msg_valid <= 1'b1;
            out_q     <= msg_from_reg((pick == CH_ONE) ? areg1 : areg0);
            last_ch   <= pick;
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    assign msg_addr = out_q.addr;
    assign msg_data = out_q.data;

endmodule

// File: rtl/irq_msg_agg.sv
module irq_msg_agg
    import irq_msg_pkg::*;
#(
    parameter int              NSRC     = 11,
    parameter logic [NSRC-1:0] SRC_USED = 11'h5FF,
    parameter logic [31:0]     ADDR_RST = 32'hF000_0003,
    parameter int              CNT_W    = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] irq_in,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [11:0]     reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            msg_valid,
    input  logic            msg_ready,
    output logic [31:0]     msg_addr,
    output logic [31:0]     msg_data
);

    logic [NSRC-1:0] level_w;
    logic [NSRC-1:0] pend_w;
    logic [NSRC-1:0] rise_w;
    logic [NSRC-1:0] ena_w;
    logic [NSRC-1:0] steer_w;
    logic [RW-1:0]   areg0_w;
    logic [RW-1:0]   areg1_w;
    logic            clr_w;

    irq_lvl_track #(.NSRC(NSRC), .SRC_USED(SRC_USED)) track_i (
        .clk      (clk),
        .rst      (rst),
        .irq_in   (irq_in),
        .clr_pend (clr_w),
        .level    (level_w),
        .pending  (pend_w),
        .rise     (rise_w)
    );

    irq_msg_regs #(.NSRC(NSRC), .ADDR_RST(ADDR_RST)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .level     (level_w),
        .pending   (pend_w),
        .areg0     (areg0_w),
        .areg1     (areg1_w),
        .ena       (ena_w),
        .steer     (steer_w),
        .clr_pend  (clr_w),
        .reg_rdata (reg_rdata)
    );

    irq_msg_queue #(.NSRC(NSRC), .CNT_W(CNT_W)) queue_i (
        .clk       (clk),
        .rst       (rst),
        .rise      (rise_w),
        .ena       (ena_w),
        .steer     (steer_w),
        .areg0     (areg0_w),
        .areg1     (areg1_w),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

endmodule

// File: rtl/irq_msg_chk.sv
module irq_msg_chk
    import irq_msg_pkg::*;
#(
    parameter int              NSRC     = 11,
    parameter logic [NSRC-1:0] SRC_USED = '1
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] irq_in,
    input logic            reg_wr,
    input logic            reg_rd,
    input logic [11:0]     reg_addr,
    input logic [NSRC-1:0] level,
    input logic [NSRC-1:0] pending,
    input logic            msg_valid,
    input logic            msg_ready,
    input logic [31:0]     msg_addr,
    input logic [31:0]     msg_data
);

    logic clr_acc;
    assign clr_acc = (reg_rd || reg_wr) && (reg_addr == OFS_PEND);

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> level == ($past(irq_in) & SRC_USED)); // R2

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((level | pending) & ~SRC_USED) == '0); // R2

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr_acc |=> (pending & $past(pending)) == $past(pending)); // R3

    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr_acc |=> (pending & $past(level)) == '0); // R4

    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R9

    AST_MSG_ALIGN: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_addr[4:0] == 5'd0) && (msg_data[31:5] == '0)); // R8

endmodule

bind irq_msg_agg irq_msg_chk #(.NSRC(NSRC), .SRC_USED(SRC_USED)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .level     (level_w),
    .pending   (pend_w),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data)
);

// File: tb/irq_msg_agg_tb_top.sv
`timescale 1ns/1ps
module irq_msg_agg_tb_top;

    localparam logic [31:0] RST_ADDR = 32'hF000_0003;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [31:0] msg_addr;
    logic [31:0] msg_data;

    int total = 0;
    int bad = 0;
    int m_cnt = 0;
    logic [31:0] m_addr [64];
    logic [31:0] m_data [64];

    always #2 clk = ~clk;

    irq_msg_agg dut_i (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .msg_valid (msg_valid),
        .msg_ready (msg_ready),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    always @(negedge clk) begin
        #1;
        if (!rst && msg_valid && msg_ready && m_cnt < 64) begin
            m_addr[m_cnt] = msg_addr;
            m_data[m_cnt] = msg_data;
            m_cnt++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_irq(input logic [10:0] v);
        @(negedge clk);
        irq_in = v;
    endtask

    task automatic quiesce();
        set_irq('0);
        idle(6);
        wr(12'h01C, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 valid", {31'd0, msg_valid}, 32'd0);
        rd(12'h028, v); check("R1 level", v, 32'd0);
        rd(12'h01C, v); check("R1 pending", v, 32'd0);
        rd(12'h018, v); check("R1 enable", v, 32'd0);
        rd(12'h024, v); check("R1 steer", v, 32'd0);
        rd(12'h004, v); check("R1 addr0", v, RST_ADDR);
        rd(12'h010, v); check("R1 addr1", v, RST_ADDR);
    endtask

    task automatic t_level_pend();
        logic [31:0] v;
        set_irq(11'h208);
        rd(12'h028, v); check("R2 level bit3, bit9 unused", v, 32'h008);
        rd(12'h01C, v); check("R3 pending set", v, 32'h008);
        set_irq('0);
        rd(12'h028, v); check("R2 level follows fall", v, 32'h000);
        rd(12'h01C, v); check("R3 pending sticky after fall", v, 32'h000);
        rd(12'h01C, v); check("R4 pending cleared by read", v, 32'h000);
    endtask

    task automatic t_pend_sticky();
        logic [31:0] v;
        set_irq(11'h010);
        set_irq('0);
        idle(2);
        rd(12'h01C, v); check("R3 sticky value on read", v, 32'h010);
        rd(12'h01C, v); check("R4 clear on read", v, 32'h000);
        set_irq(11'h020);
        wr(12'h01C, 32'hFFFF_FFFF);
        rd(12'h01C, v); check("R4 clear on write", v, 32'h000);
        quiesce();
    endtask

    task automatic t_glitch();
        logic [31:0] v;
        @(negedge clk);
        #0.5 irq_in = 11'h004;
        #1.0 irq_in = 11'h000;
        idle(2);
        rd(12'h028, v); check("R2 short pulse level", v, 32'h0);
        rd(12'h01C, v); check("R2 short pulse pending", v, 32'h0);
    endtask

    task automatic t_views();
        logic [31:0] v;
        wr(12'h018, 32'h00F);
        wr(12'h024, 32'h00A);
        set_irq(11'h03F);
        idle(6);
        rd(12'h00C, v); check("R5 view0", v, 32'h005);
        rd(12'h014, v); check("R5 view1", v, 32'h00A);
        wr(12'h00C, 32'hFFFF_FFFF);
        wr(12'h014, 32'h0);
        wr(12'h028, 32'h0);
        rd(12'h00C, v); check("R6 view0 write ignored", v, 32'h005);
        rd(12'h014, v); check("R6 view1 write ignored", v, 32'h00A);
        rd(12'h028, v); check("R6 level write ignored", v, 32'h03F);
        quiesce();
    endtask

    task automatic t_steer();
        logic [31:0] v;
        int n;
        wr(12'h004, 32'h1234_5667);
        wr(12'h010, 32'h0ABC_DEF3);
        wr(12'h018, 32'h401);
        wr(12'h024, 32'h400);
        n = m_cnt;
        set_irq(11'h001);
        idle(6);
        check("R7 one message ch0", m_cnt - n, 1);
        check("R8 addr from reg0", m_addr[n], 32'h1234_5660);
        check("R8 data from reg0", m_data[n], 32'h0000_0007);
        n = m_cnt;
        set_irq(11'h401);
        idle(6);
        check("R7 one message ch1", m_cnt - n, 1);
        check("R8 addr from reg1", m_addr[n], 32'h0ABC_DEE0);
        check("R8 data from reg1", m_data[n], 32'h0000_0013);
        n = m_cnt;
        set_irq(11'h421);
        idle(6);
        check("R7 masked line no message", m_cnt - n, 0);
        rd(12'h01C, v); check("R7 masked line pending", v & 32'h20, 32'h20);
        quiesce();
    endtask

    task automatic t_hold();
        int n;
        wr(12'h018, 32'h001);
        wr(12'h024, 32'h000);
        n = m_cnt;
        msg_ready = 1'b0;
        set_irq(11'h001);
        @(negedge clk); #1;
        check("R7 latency not yet valid", {31'd0, msg_valid}, 32'd0);
        @(negedge clk); #1;
        check("R7 latency valid", {31'd0, msg_valid}, 32'd1);
        set_irq('0);
        set_irq(11'h001);
        idle(3); #1;
        check("R9 valid held", {31'd0, msg_valid}, 32'd1);
        check("R9 addr held", msg_addr, 32'h1234_5660);
        @(negedge clk);
        msg_ready = 1'b1;
        idle(6);
        check("R10 stacked trigger delivered", m_cnt - n, 2);
        quiesce();
        n = m_cnt;
        wr(12'h018, 32'h003);
        set_irq(11'h003);
        idle(6);
        check("R10 simultaneous rises", m_cnt - n, 2);
        quiesce();
    endtask

    task automatic t_alt();
        int n;
        int same;
        int c0;
        wr(12'h018, 32'h003);
        wr(12'h024, 32'h002);
        n = m_cnt;
        msg_ready = 1'b0;
        set_irq(11'h003);
        set_irq('0);
        set_irq(11'h003);
        set_irq('0);
        idle(3);
        @(negedge clk);
        msg_ready = 1'b1;
        idle(10);
        check("R11 message count", m_cnt - n, 4);
        same = 0;
        c0 = 0;
        for (int k = n; k < n + 4 && k < 64; k++) begin
            if (m_addr[k] == 32'h1234_5660) c0++;
            if (k > n && m_addr[k] == m_addr[k-1]) same++;
        end
        check("R11 alternation", same, 0);
        check("R11 two per channel", c0, 2);
        quiesce();
    endtask

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        t_reset();
        t_level_pend();
        t_pend_sticky();
        t_glitch();
        t_views();
        t_steer();
        t_hold();
        t_alt();
        idle(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule